// File: doc/BRIEF.md
# Status Flag Update Unit

This block keeps the architectural condition flags of an integer datapath and rewrites them after each retired operation. Each cycle with the update strobe high it receives the operation's result, whether the operation ran at 32-bit or 64-bit width, and a two-bit operation class. Bitwise logic operations recompute the zero, sign and parity flags from the result and force carry and overflow low. Compare-style operations recompute the same three flags but take carry, overflow and auxiliary carry from the arithmetic unit. Register moves, including a move of the constant zero, write no flag at all.

A small branch evaluator reads the held zero flag to answer a "jump if zero" query. The query sees the flag as stored at that moment. An update presented in the same cycle becomes visible one cycle later. This is why a self-XOR placed between a compare and its branch forces the branch to be taken, while a move of zero in the same position leaves the compare's outcome intact.

Top module: `status_flag_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, all six flag bits in `flags_o` are 0. The bit positions are [0] carry, [1] parity, [2] auxiliary carry, [3] zero, [4] sign, [5] overflow.
- R2: After an accepted logic op (`op_class`=2'b00) or compare op (2'b10), the zero flag is 1 exactly when the result is zero at the operating width. With `wide_op`=0 only bits [31:0] are tested.
- R3: After a logic or compare op, the sign flag equals `result[63]` when `wide_op`=1 and `result[31]` when `wide_op`=0.
- R4: After a logic or compare op, the parity flag is 1 when `result[7:0]` holds an even number of one bits. A zero result therefore gives parity 1.
- R5: After a logic op, carry and overflow are 0.
- R6: After a logic op, the auxiliary-carry flag keeps its previous value.
- R7: A move op (`op_class`=2'b01) and the unused class 2'b11 leave all six flags unchanged.
- R8: After a compare op, carry, overflow and auxiliary carry take the values of `cmp_carry`, `cmp_ovf` and `cmp_aux`.
- R9: When `upd_valid` is low, the flags do not change, whatever the other inputs are.
- R10: `br_taken` equals `br_query` AND the stored zero flag. An update accepted in the same cycle affects the answer only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Flag update strobe |
| op_class | input | 2 | 00 logic, 01 move, 10 compare, 11 no write |
| wide_op | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| result | input | 64 | Result value of the operation |
| cmp_carry | input | 1 | Carry supplied for compare ops |
| cmp_ovf | input | 1 | Overflow supplied for compare ops |
| cmp_aux | input | 1 | Auxiliary carry supplied for compare ops |
| br_query | input | 1 | "Jump if zero" query |
| flags_o | output | 6 | Stored flags {overflow, sign, zero, aux, parity, carry} |
| br_taken | output | 1 | Query answer: branch taken |

## Verification
The flag update and the branch query can fall in the same cycle. The key case is a compare that clears the zero flag, followed by a zero-producing logic op issued together with a query. The query must still see the compare's outcome, and a query one cycle later must see the forced zero flag. A move of zero in the same position must leave that second query not taken. The random phase raises `br_query` and `upd_valid` independently. On every cycle the branch answer is judged against the bench's flag model before that cycle's update is applied.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  localparam int DATA_W   = 64;
  localparam int NARROW_W = 32;
  localparam int PAR_W    = 8;

  typedef enum logic [1:0] {
    OPC_LOGIC = 2'b00,
    OPC_MOVE  = 2'b01,
    OPC_CMP   = 2'b10,
    OPC_NONE  = 2'b11
  } op_class_e;

  // Packed order gives bit 5 = of ... bit 0 = cf
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  function automatic logic f_is_zero(input logic [DATA_W-1:0] v, input logic wide);
    logic [DATA_W-1:0] mask;
    mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    return (v & mask) == '0;
  endfunction

  function automatic logic f_sign(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v[DATA_W-1] : v[NARROW_W-1];
  endfunction

  function automatic logic f_even_parity(input logic [DATA_W-1:0] v);
    return ~(^v[PAR_W-1:0]);
  endfunction

endpackage

// File: rtl/flagu_calc.sv
module flagu_calc
  import flagu_pkg::*;
(
  input  logic              valid,
  input  op_class_e         op,
  input  logic              wide,
  input  logic [DATA_W-1:0] res,
  input  logic              ext_cf,
  input  logic              ext_of,
  input  logic              ext_af,
  input  flags_t            cur,
  output flags_t            nxt,
  output logic              wr_en,
  output logic              zero_hit
);

  logic sign_bit;
  logic par_bit;

  assign zero_hit = f_is_zero(res, wide);
  assign sign_bit = f_sign(res, wide);
  assign par_bit  = f_even_parity(res);

  always_comb begin
    nxt   = cur;
    wr_en = 1'b0;
    unique case (op)
      OPC_LOGIC: begin
        nxt.zf = zero_hit;
        nxt.sf = sign_bit;
        nxt.pf = par_bit;
        nxt.cf = 1'b0;
        nxt.of = 1'b0;
        wr_en  = valid;
      end
      OPC_CMP: begin
        nxt.zf = zero_hit;
        nxt.sf = sign_bit;
        nxt.pf = par_bit;
        nxt.cf = ext_cf;
        nxt.of = ext_of;
        nxt.af = ext_af;
        wr_en  = valid;
      end
      default: begin
        wr_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flagu_reg.sv
module flagu_reg
  import flagu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  flags_t nxt,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= nxt;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R9

endmodule

// File: rtl/flagu_branch.sv
module flagu_branch
  import flagu_pkg::*;
(
  input  logic   query,
  input  flags_t flags,
  output logic   taken
);

  assign taken = query & flags.zf;

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flagu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [1:0]        op_class,
  input  logic              wide_op,
  input  logic [DATA_W-1:0] result,
  input  logic              cmp_carry,
  input  logic              cmp_ovf,
  input  logic              cmp_aux,
  input  logic              br_query,
  output logic [FLAG_W-1:0] flags_o,
  output logic              br_taken
);

  op_class_e op;
  flags_t    cur;
  flags_t    nxt;
  logic      wr_en;
  logic      zero_hit;
  logic      logic_upd;
  logic      move_upd;
  logic      flag_upd;

  assign op        = op_class_e'(op_class);
  assign logic_upd = upd_valid && (op == OPC_LOGIC);
  assign move_upd  = upd_valid && (op == OPC_MOVE);
  assign flag_upd  = upd_valid && (op == OPC_LOGIC || op == OPC_CMP);

  flagu_calc u_calc (
    .valid    (upd_valid),
    .op       (op),
    .wide     (wide_op),
    .res      (result),
    .ext_cf   (cmp_carry),
    .ext_of   (cmp_ovf),
    .ext_af   (cmp_aux),
    .cur      (cur),
    .nxt      (nxt),
    .wr_en    (wr_en),
    .zero_hit (zero_hit)
  );

  flagu_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .nxt   (nxt),
    .q     (cur)
  );

  flagu_branch u_br (
    .query (br_query),
    .flags (cur),
    .taken (br_taken)
  );

  assign flags_o = cur;

  AST_MOVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    move_upd |=> $stable(flags_o)); // R7

  AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
    logic_upd |=> (!flags_o[0] && !flags_o[5])); // R5

  AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    logic_upd |=> $stable(flags_o[2])); // R6

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> !(flags_o[3] && flags_o[4])); // R3

  AST_ZERO_EVEN_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (!flags_o[3] || flags_o[1])); // R4

  AST_ZERO_THEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_upd && zero_hit) |=> (!br_query || br_taken)); // R10

endmodule

// File: tb/status_flag_unit_test.sv
module status_flag_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid;
  logic [1:0]  op_class;
  logic        wide_op;
  logic [63:0] result;
  logic        cmp_carry, cmp_ovf, cmp_aux;
  logic        br_query;
  logic [5:0]  flags_o;
  logic        br_taken;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // model flags {of, sf, zf, af, pf, cf}
  logic [5:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
    .wide_op(wide_op), .result(result), .cmp_carry(cmp_carry), .cmp_ovf(cmp_ovf),
    .cmp_aux(cmp_aux), .br_query(br_query), .flags_o(flags_o), .br_taken(br_taken)
  );

  function automatic int ones_low_byte(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [5:0] expect_flags(input logic [5:0] old, input logic v,
      input logic [1:0] opc, input logic w, input logic [63:0] r,
      input logic c, input logic o, input logic a);
    logic [5:0] e;
    logic z, s, p;
    e = old;
    z = w ? (r == 64'd0) : (r[31:0] == 32'd0);
    s = w ? r[63] : r[31];
    p = (ones_low_byte(r) % 2) == 0;
    if (v && opc == 2'b00) e = {1'b0, s, z, old[2], p, 1'b0};
    if (v && opc == 2'b10) e = {o, s, z, a, p, c};
    return e;
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, judge branch before the edge, judge flags after it
  task automatic step(input string tag, input logic v, input logic [1:0] opc,
      input logic w, input logic [63:0] r, input logic c, input logic o,
      input logic a, input logic q);
    upd_valid = v; op_class = opc; wide_op = w; result = r;
    cmp_carry = c; cmp_ovf = o; cmp_aux = a; br_query = q;
    #1;
    check("R10", {5'd0, br_taken}, {5'd0, q & model[3]});
    @(posedge clk);
    model = expect_flags(model, v, opc, w, r, c, o, a);
    @(negedge clk);
    check(tag, flags_o, model);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [1:0] opc;
    logic [63:0] r;
    string tag;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 1'b0; upd_valid = 1'b1; op_class = 2'b10; wide_op = 1'b1;
    result = 64'h8000_0000_0000_0001; cmp_carry = 1; cmp_ovf = 1; cmp_aux = 1;
    br_query = 1'b0;
    model = '0;
    repeat (3) @(negedge clk);
    check("R1", flags_o, 6'b0);
    rst_n = 1'b1; upd_valid = 1'b0;
    @(negedge clk);
    check("R1", flags_o, 6'b0);

    // compare setting aux and carry, nonzero result: zf=0
    step("R8", 1, 2'b10, 1, 64'h0000_0000_0000_0003, 1, 1, 1, 0);
    // logic op: aux must stay 1, cf/of cleared
    step("R6", 1, 2'b00, 1, 64'h0000_0000_0000_0001, 1, 1, 0, 0);
    step("R5", 1, 2'b00, 1, 64'h0000_0000_0000_0007, 1, 1, 0, 0);
    // compare nonzero, then move zero with same-cycle query
    step("R8", 1, 2'b10, 1, 64'h10, 0, 1, 0, 0);
    step("R7", 1, 2'b01, 1, 64'h0, 1, 1, 1, 1);
    step("R10", 0, 2'b00, 1, 64'h0, 0, 0, 0, 1);
    // self-XOR result zero with same-cycle query: not taken now, taken next
    step("R2", 1, 2'b00, 1, 64'h0, 0, 0, 0, 1);
    step("R10", 0, 2'b10, 1, 64'h5, 1, 1, 1, 1);
    // 32-bit: upper half ignored for zero
    step("R2", 1, 2'b00, 0, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0);
    // sign bit selection
    step("R3", 1, 2'b00, 0, 64'h0000_0000_8000_0000, 0, 0, 0, 0);
    step("R3", 1, 2'b00, 1, 64'h0000_0000_8000_0000, 0, 0, 0, 0);
    step("R3", 1, 2'b00, 1, 64'h8000_0000_0000_0000, 0, 0, 0, 0);
    // parity: 0x03 even, 0x07 odd, upper bits ignored
    step("R4", 1, 2'b00, 1, 64'hFF00_0000_0000_0003, 0, 0, 0, 0);
    step("R4", 1, 2'b00, 1, 64'h0000_0000_0000_FF07, 0, 0, 0, 0);
    // unused class and idle strobe keep flags
    step("R7", 1, 2'b11, 1, 64'h0, 1, 1, 1, 1);
    step("R9", 0, 2'b10, 1, 64'h0, 1, 1, 1, 1);

    for (int i = 0; i < N_RANDOM; i++) begin
      opc = 2'($urandom_range(0, 3));
      r = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) r = 64'd0;
      if ($urandom_range(0, 7) == 0) r[31:0] = 32'd0;
      case (opc)
        2'b00: tag = "R5";
        2'b01: tag = "R7";
        2'b10: tag = "R8";
        default: tag = "R7";
      endcase
      if ($urandom_range(0, 4) == 0) tag = "R9";
      step(tag, (tag != "R9"), opc, 1'($urandom), r, 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule